// File: doc/BRIEF.md
# Zone-Selectable Quantizing 2D DCT Sequencer

This block controls the second half of an 8x8 separable two-dimensional DCT. The first-pass (row) coefficients of one block arrive as a stream, 64 words in row-major order. The block trims each word to its storage precision and keeps it in an 8x8 transpose store. A 2-bit zone code picks a square low-frequency region of k×k coefficients, with k running from 2 to 5. Only the first k columns of the store are sent to an external column-transform engine, one column per request.

From each column the engine returns eight second-pass values. The block keeps the first k of them. It then streams out all 64 final coefficients in row-major order. Every coefficient inside the zone is cut to a fixed width that depends on its ring, meaning its distance from DC. Every coefficient outside the zone is zero. Because the zone controls both how much work is done and how coarse the result is, it acts as a compression-ratio setting.

All three data interfaces use valid/ready. A transfer happens on a rising edge where both are high. A source holding valid high may not change its payload or drop valid until the transfer happens. The block accepts no new block while one is still in progress. A low `out_ready` stalls output emission indefinitely, a low `col_req_ready` stalls the column phase, and a late response simply extends it.

Top module: `dct2d_zone_ctrl`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `busy` is 0, `in_ready` is 1, `col_req_valid` is 0 and `out_valid` is 0.
- R2: Zone codes 0, 1, 2 and 3 select k = 2, 3, 4 and 5. The code is sampled when the first coefficient of a block is accepted, and later changes have no effect on that block's requests or outputs.
- R3: `in_ready` is high only while a block is being loaded. It is low from the cycle after the 64th accepted word until the cycle after the last output is accepted. `busy` is high from the cycle after the first word is accepted until the cycle after the last output is accepted.
- R4: A word at column 0 of its row is stored unchanged (11 bits). Words at columns 1 to 7 are stored as the word arithmetically shifted right by 3 and sign-extended to 11 bits. Request vectors carry stored row r in bits [r*11 +: 11].
- R5: Each block makes exactly k column requests, with `col_req_idx` = 0, 1, …, k-1 in order. The next request is not raised until the response to the previous one has been accepted.
- R6: While `col_req_valid` is high and `col_req_ready` is low, the request index and vector hold steady.
- R7: Each block emits exactly 64 coefficients in row-major order. `out_row` and `out_col` give the position, and `out_last` is high only at row 7, column 7.
- R8: Any coefficient with row ≥ k or column ≥ k is emitted as 0.
- R9: Coefficient (0,0) equals element 0 of the column-0 response, at the full 14 bits.
- R10: Every other in-zone coefficient (u,v) has ring r = max(u,v). It equals element u of the column-v response arithmetically shifted right by 4+r and sign-extended to 14 bits. This gives 9, 8, 7 and 6 significant bits for rings 1 to 4.
- R11: While `out_valid` is high and `out_ready` is low, every output field holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| zone_sel | input | 2 | Zone code, sampled with a block's first word |
| busy | output | 1 | A block is in progress |
| in_valid | input | 1 | First-pass word valid |
| in_ready | output | 1 | Block accepts a first-pass word |
| in_coef | input | 11 | First-pass coefficient, signed, row-major |
| col_req_valid | output | 1 | Column request valid |
| col_req_ready | input | 1 | Engine accepts the request |
| col_req_idx | output | 3 | Column index of the request |
| col_req_vec | output | 88 | Eight stored values of the column, row r at [r*11 +: 11] |
| col_rsp_valid | input | 1 | Engine response valid |
| col_rsp_ready | output | 1 | Block accepts the response |
| col_rsp_vec | input | 112 | Eight second-pass values, element u at [u*14 +: 14], signed |
| out_valid | output | 1 | Final coefficient valid |
| out_ready | input | 1 | Consumer accepts the coefficient |
| out_coef | output | 14 | Quantized coefficient, signed |
| out_row | output | 3 | Vertical frequency index |
| out_col | output | 3 | Horizontal frequency index |
| out_last | output | 1 | Last coefficient of the block |

## Verification
The first column request is valid on the cycle after the 64th word is accepted. Each later request rises on the cycle after the previous response is accepted. The first output is valid on the cycle after the k-th response is accepted, and `busy` falls one cycle after the 64th output is accepted. The bench drives and samples only on falling edges and waits on the handshake signals rather than fixed delays. It can therefore check each result exactly one edge after the transfer that caused it, even under the random-free but irregular stalls it applies on the input, response and output sides. Expected outputs come from the bench's own copy of the input words, its own model of the column engine, and the ring-width rule.

// File: rtl/dctz_pkg.sv
`timescale 1ns/1ps
package dctz_pkg;
  localparam int unsigned BLK_N = 8;

  typedef enum logic [1:0] {
    ST_LOAD,
    ST_REQ,
    ST_RSP,
    ST_EMIT
  } dctz_state_e;

  // Right-shift amount for a ring; ring 0 keeps the full width,
  // ring 1 keeps ac1_w bits and each further ring one bit fewer.
  function automatic int ring_shift(input int out_w, input int ac1_w, input int ring);
    if (ring == 0) return 0;
    return out_w - ac1_w + ring - 1;
  endfunction
endpackage

// File: rtl/dctz_pretrunc.sv
`timescale 1ns/1ps
module dctz_pretrunc #(
  parameter int W    = 11,
  parameter int AC_W = 8,
  parameter int IW   = 3
) (
  input  logic [IW-1:0] col,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);
  localparam int SH = W - AC_W;

  always_comb begin
    if (col == '0) dout = din;
    else           dout = $unsigned($signed(din) >>> SH);
  end
endmodule

// File: rtl/dctz_tbuf.sv
`timescale 1ns/1ps
module dctz_tbuf #(
  parameter int W = 11,
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [W-1:0]      wr_data,
  input  logic [IW-1:0]     rd_col,
  output logic [N*W-1:0]    rd_vec
);
  localparam int IW = $clog2(N);
  localparam int AW = 2 * IW;

  logic [W-1:0] mem [N*N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar r = 0; r < N; r++) begin : g_rd
    assign rd_vec[r*W +: W] = mem[{IW'(r), rd_col}];
  end
endmodule

// File: rtl/dctz_zone_quant.sv
`timescale 1ns/1ps
module dctz_zone_quant
  import dctz_pkg::*;
#(
  parameter int OUT_W = 14,
  parameter int AC1_W = 9,
  parameter int IW    = 3,
  parameter int K_W   = 3
) (
  input  logic [IW-1:0]    row,
  input  logic [IW-1:0]    col,
  input  logic [K_W-1:0]   k,
  input  logic [OUT_W-1:0] raw,
  output logic [OUT_W-1:0] q
);
  logic [IW-1:0] rng;
  logic          in_zone;
  int            sh;

  always_comb begin
    rng     = (row > col) ? row : col;
    in_zone = (K_W'(row) < k) && (K_W'(col) < k);
    sh      = ring_shift(OUT_W, AC1_W, int'(rng));
    if (in_zone) q = $unsigned($signed(raw) >>> sh);
    else         q = '0;
  end
endmodule

// File: rtl/dct2d_zone_ctrl.sv
`timescale 1ns/1ps
module dct2d_zone_ctrl
  import dctz_pkg::*;
#(
  parameter int IN_W   = 11,
  parameter int AC_W   = 8,
  parameter int OUT_W  = 14,
  parameter int AC1_W  = 9,
  parameter int ZSEL_W = 2,
  parameter int KMIN   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ZSEL_W-1:0]          zone_sel,
  output logic                       busy,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [IN_W-1:0]            in_coef,
  output logic                       col_req_valid,
  input  logic                       col_req_ready,
  output logic [2:0]                 col_req_idx,
  output logic [BLK_N*IN_W-1:0]      col_req_vec,
  input  logic                       col_rsp_valid,
  output logic                       col_rsp_ready,
  input  logic [BLK_N*OUT_W-1:0]     col_rsp_vec,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [OUT_W-1:0]           out_coef,
  output logic [2:0]                 out_row,
  output logic [2:0]                 out_col,
  output logic                       out_last
);
  localparam int N    = BLK_N;
  localparam int NC   = N * N;
  localparam int IW   = $clog2(N);
  localparam int CW   = $clog2(NC);
  localparam int MAXK = KMIN + (1 << ZSEL_W) - 1;
  localparam int K_W  = $clog2(MAXK + 1);

  dctz_state_e     state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   col_idx;
  logic [K_W-1:0]  zone_k;
  logic [IN_W-1:0] st_word;
  logic            ld_fire;
  logic [OUT_W-1:0] res [MAXK][MAXK];
  logic [IW-1:0]   em_row, em_col, rd_r, rd_c;

  assign ld_fire = in_valid && in_ready;
  assign em_row  = cnt[CW-1 -: IW];
  assign em_col  = cnt[IW-1:0];

  // Control sequence: load 64 words, k request/response pairs, emit 64.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      cnt     <= '0;
      col_idx <= '0;
      zone_k  <= K_W'(KMIN);
    end else begin
      case (state)
        ST_LOAD: if (in_valid) begin
          if (cnt == '0) zone_k <= K_W'(zone_sel) + K_W'(KMIN);
          if (cnt == CW'(NC-1)) begin
            state   <= ST_REQ;
            cnt     <= '0;
            col_idx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REQ: if (col_req_ready) state <= ST_RSP;
        ST_RSP: if (col_rsp_valid) begin
          if (K_W'(col_idx) == zone_k - 1'b1) state <= ST_EMIT;
          else begin
            col_idx <= col_idx + 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_EMIT: if (out_ready) begin
          if (cnt == CW'(NC-1)) state <= ST_LOAD;
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // Keep the low-frequency part of each column response.
  always_ff @(posedge clk) begin
    if (state == ST_RSP && col_rsp_valid) begin
      for (int u = 0; u < MAXK; u++)
        res[u][col_idx] <= col_rsp_vec[u*OUT_W +: OUT_W];
    end
  end

  dctz_pretrunc #(.W(IN_W), .AC_W(AC_W), .IW(IW)) u_pretrunc (
    .col  (cnt[IW-1:0]),
    .din  (in_coef),
    .dout (st_word)
  );

  dctz_tbuf #(.W(IN_W), .N(N)) u_tbuf (
    .clk     (clk),
    .wr_en   (ld_fire),
    .wr_idx  (cnt),
    .wr_data (st_word),
    .rd_col  (col_idx),
    .rd_vec  (col_req_vec)
  );

  assign rd_r = (int'(em_row) < MAXK) ? em_row : '0;
  assign rd_c = (int'(em_col) < MAXK) ? em_col : '0;

  dctz_zone_quant #(.OUT_W(OUT_W), .AC1_W(AC1_W), .IW(IW), .K_W(K_W)) u_quant (
    .row (em_row),
    .col (em_col),
    .k   (zone_k),
    .raw (res[rd_r][rd_c]),
    .q   (out_coef)
  );

  assign in_ready      = (state == ST_LOAD);
  assign busy          = !((state == ST_LOAD) && (cnt == '0));
  assign col_req_valid = (state == ST_REQ);
  assign col_req_idx   = col_idx;
  assign col_rsp_ready = (state == ST_RSP);
  assign out_valid     = (state == ST_EMIT);
  assign out_row       = em_row;
  assign out_col       = em_col;
  assign out_last      = (state == ST_EMIT) && (cnt == CW'(NC-1));
endmodule

// File: rtl/dctz_chk.sv
`timescale 1ns/1ps
module dctz_chk #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          zone_sel,
  input logic                busy,
  input logic                in_valid,
  input logic                in_ready,
  input logic                col_req_valid,
  input logic                col_req_ready,
  input logic [2:0]          col_req_idx,
  input logic [8*IN_W-1:0]   col_req_vec,
  input logic                col_rsp_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [OUT_W-1:0]    out_coef,
  input logic [2:0]          out_row,
  input logic [2:0]          out_col,
  input logic                out_last
);
  logic [2:0] chk_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_k <= 3'd2;
    else if (in_valid && in_ready && !busy) chk_k <= {1'b0, zone_sel} + 3'd2;
  end

  assert_idle_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (in_ready && !out_valid && !col_req_valid));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || col_req_valid || col_rsp_ready) |-> !in_ready);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_req_valid && !col_req_ready) |=>
      (col_req_valid && $stable(col_req_idx) && $stable(col_req_vec)));

  assert_req_in_zone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_req_valid |-> (col_req_idx < chk_k));

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_coef) && $stable(out_row) && $stable(out_col) && $stable(out_last)));

  assert_last_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_row == 3'd7 && out_col == 3'd7));

  assert_zero_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ({1'b0, out_row} >= {1'b0, chk_k} || {1'b0, out_col} >= {1'b0, chk_k}))
      |-> (out_coef == '0));
endmodule

bind dct2d_zone_ctrl dctz_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .zone_sel      (zone_sel),
  .busy          (busy),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .col_req_valid (col_req_valid),
  .col_req_ready (col_req_ready),
  .col_req_idx   (col_req_idx),
  .col_req_vec   (col_req_vec),
  .col_rsp_ready (col_rsp_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_coef      (out_coef),
  .out_row       (out_row),
  .out_col       (out_col),
  .out_last      (out_last)
);

// File: tb/dct2d_zone_ctrl_bench.sv
`timescale 1ns/1ps
module dct2d_zone_ctrl_bench;
  localparam int IN_W  = 11;
  localparam int OUT_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]          zone_sel = '0;
  logic                busy, in_ready, col_req_valid, col_rsp_ready, out_valid, out_last;
  logic                in_valid = 1'b0;
  logic [IN_W-1:0]     in_coef = '0;
  logic                col_req_ready = 1'b0;
  logic [2:0]          col_req_idx, out_row, out_col;
  logic [8*IN_W-1:0]   col_req_vec;
  logic                col_rsp_valid = 1'b0;
  logic [8*OUT_W-1:0]  col_rsp_vec = '0;
  logic                out_ready = 1'b0;
  logic [OUT_W-1:0]    out_coef;

  dct2d_zone_ctrl u_dct2d_zone_ctrl (
    .clk(clk), .rst_n(rst_n), .zone_sel(zone_sel), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
    .col_req_valid(col_req_valid), .col_req_ready(col_req_ready),
    .col_req_idx(col_req_idx), .col_req_vec(col_req_vec),
    .col_rsp_valid(col_rsp_valid), .col_rsp_ready(col_rsp_ready), .col_rsp_vec(col_rsp_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef),
    .out_row(out_row), .out_col(out_col), .out_last(out_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit all_done = 0;
  bit blk_done;
  int req_seen;
  logic signed [IN_W-1:0] blk_in [64];
  int rsp_mem [8][8];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pat(input int seed, input int i);
    case (seed)
      1:       return (i % 2 == 1) ? 1023 : -1024;
      2:       return ((i * i * 13 + i * 7 + 5) % 2048) - 1024;
      default: return ((i * 37 + seed * 101 + 11) % 2048) - 1024;
    endcase
  endfunction

  // Bench model of the column engine.
  function automatic int col_model(input int stored, input int c, input int u);
    return 3 * stored + 17 * c - 5 * u;
  endfunction

  function automatic int stored_val(input int r, input int c);
    if (c == 0) return int'(blk_in[r*8 + c]);
    return int'(blk_in[r*8 + c] >>> 3);
  endfunction

  task automatic feeder(input int zone, input bit stall, input int zone_late);
    zone_sel = zone[1:0];
    for (int i = 0; i < 64; i++) begin
      if (stall && (i % 5 == 3)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_coef  = blk_in[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0 && zone_late >= 0) zone_sel = zone_late[1:0];
    end
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R3", "in_ready after 64th word", int'(in_ready), 0);
  endtask

  task automatic responder(input bit stall);
    while (!blk_done) begin
      @(negedge clk);
      if (col_req_valid && !blk_done) begin
        int c;
        c = int'(col_req_idx);
        check(c == req_seen, "R5", "column order", c, req_seen);
        for (int r = 0; r < 8; r++)
          check($signed(col_req_vec[r*IN_W +: IN_W]) == stored_val(r, c), "R4",
                "stored column word", int'($signed(col_req_vec[r*IN_W +: IN_W])), stored_val(r, c));
        if (stall) begin
          @(negedge clk);
          // R6: request held while not accepted
          check(col_req_valid && int'(col_req_idx) == c, "R6", "request hold",
                int'(col_req_idx), c);
        end
        req_seen++;
        col_req_ready = 1'b1;
        @(negedge clk);
        col_req_ready = 1'b0;
        if (stall) repeat (2) @(negedge clk);
        for (int u = 0; u < 8; u++) begin
          rsp_mem[c][u] = col_model(stored_val(u, c), c, u);
          col_rsp_vec[u*OUT_W +: OUT_W] = OUT_W'(rsp_mem[c][u]);
        end
        col_rsp_valid = 1'b1;
        while (!col_rsp_ready) @(negedge clk);
        @(negedge clk);
        col_rsp_valid = 1'b0;
      end
    end
  endtask

  task automatic collector(input int k, input bit stall);
    int got = 0;
    int cyc = 0;
    bit held = 0;
    int h_coef, h_row, h_col;
    while (got < 64) begin
      @(negedge clk);
      cyc++;
      if (held) begin
        // R11: fields unchanged under back-pressure
        check(out_valid && int'($signed(out_coef)) == h_coef && int'(out_row) == h_row
              && int'(out_col) == h_col, "R11", "output hold", int'($signed(out_coef)), h_coef);
        held = 0;
      end
      out_ready = !stall || (cyc % 3 != 0);
      if (out_valid && !out_ready) begin
        held = 1;
        h_coef = int'($signed(out_coef));
        h_row = int'(out_row);
        h_col = int'(out_col);
      end
      if (out_valid && out_ready) begin
        int u, v, e, r;
        string tag;
        u = got / 8;
        v = got % 8;
        check(int'(out_row) == u && int'(out_col) == v, "R7", "position",
              int'(out_row) * 8 + int'(out_col), got);
        check(out_last == (got == 63), "R7", "last flag", int'(out_last), int'(got == 63));
        if (u >= k || v >= k) begin
          e = 0; tag = "R8";
        end else if (u == 0 && v == 0) begin
          e = rsp_mem[0][0]; tag = "R9";
        end else begin
          r = (u > v) ? u : v;
          e = rsp_mem[v][u] >>> (4 + r); tag = "R10";
        end
        check(int'($signed(out_coef)) == e, tag, $sformatf("coef(%0d,%0d)", u, v),
              int'($signed(out_coef)), e);
        check(!in_ready && busy, "R3", "closed while emitting", int'(in_ready), 0);
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    blk_done = 1;
    check(!busy && in_ready, "R3", "reopen after last output", int'(busy), 0);
  endtask

  task automatic do_block(input int zone, input int seed, input bit stall, input int zone_late);
    for (int i = 0; i < 64; i++) blk_in[i] = IN_W'(pat(seed, i));
    blk_done = 0;
    req_seen = 0;
    fork
      feeder(zone, stall, zone_late);
      responder(stall);
      collector(zone + 2, stall);
    join
    check(req_seen == zone + 2, "R5", "request count", req_seen, zone + 2);
  endtask

  task automatic t_reset_state;
    check(!busy && in_ready && !col_req_valid && !out_valid, "R1", "state during reset",
          int'({busy, in_ready, col_req_valid, out_valid}), 4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && in_ready && !col_req_valid && !out_valid, "R1", "state after reset",
          int'({busy, in_ready, col_req_valid, out_valid}), 4);
  endtask

  task automatic t_zone1_plain;    // zone code 0 -> 2x2
    do_block(0, 0, 0, -1);
  endtask

  task automatic t_zone4_stalls;   // zone code 3 -> 5x5, stalls everywhere (R6, R11)
    do_block(3, 2, 1, -1);
  endtask

  task automatic t_zone_late_change; // R2: code 1 sampled, then changed to 3
    do_block(1, 3, 0, 3);
  endtask

  task automatic t_extremes;       // zone code 2 -> 4x4, full-scale words
    do_block(2, 1, 1, -1);
  endtask

  task automatic t_back_to_back;   // two blocks, second with a smaller zone
    do_block(3, 4, 0, -1);
    do_block(0, 5, 0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog: actual no completion expected completion within %0d cycles", 150000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_zone1_plain();
    t_zone4_stalls();
    t_zone_late_change();
    t_extremes();
    t_back_to_back();
    all_done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule